// File: doc/BRIEF.md
# Serial Port Status Flags and Interrupt Combiner

This block holds the eight status flags of a serial transmit/receive port and merges them into one interrupt request. The transmitter and receiver report events as one-cycle pulses: the pending transmit byte moved into the shifter, the final frame finished, a byte received, an overrun, an idle line, noise, a framing fault and a parity fault. The register bus reports accesses with single-cycle strobes: a status read, a data read, a data write, and an access to any other register of the port. Each strobe or event is sampled on the rising clock edge, and the flags change on that same edge.

Flags clear only through a two-step bus sequence. A status read arms the clear. The next access to the data register then does the clearing. A data write clears the transmit-side pair. A data read clears the six receive-side flags. The transmitter may load a new byte into its shifter only while the block reports that the transmit buffer is no longer empty-flagged.

Five enable inputs choose which flags can raise the shared interrupt line. A global mask input silences that line. A low-power mode input adds two behaviours. In wait mode, an enabled pending flag requests wake-up. In halt mode, the block freezes. No data moves through this block, so every pin is a plain level or a one-cycle pulse, and there is no valid/ready handshake and no back-pressure.

Top module: `uart_stat_irq`

## Requirements
- R1: `status` carries the flags at fixed positions:
  - bit 7: transmit buffer empty
  - bit 6: transmission complete
  - bit 5: receive data ready
  - bit 4: idle line
  - bit 3: overrun
  - bit 2: noise
  - bit 1: framing error
  - bit 0: parity error

  No bus write changes a flag directly.
- R2: After reset, `status` is 8'hC0, `load_ok` is low and the clear sequence is unarmed.
- R3: A `ev_txbuf_moved` pulse sets bit 7 on the edge that samples it.
- R4: Bits 7 and 6 clear only on a data write that is sampled while the sequence is armed. A status read arms the sequence on the edge that samples it. A data write with no armed sequence leaves both bits unchanged.
- R5: `load_ok` is high exactly when bit 7 is clear.
- R6: A `ev_frame_done` pulse sets bit 6.
- R7: The events `ev_rx_byte`, `ev_idle`, `ev_overrun`, `ev_noise`, `ev_frame_err` and `ev_parity_err` set bits 5, 4, 3, 2, 1 and 0. A data read sampled while the sequence is armed clears all six of these bits.
- R8: An event sampled on the same edge as a clear leaves its own flag set. The other flags in that clear group still clear.
- R9: Any data access (read or write) consumes the armed state. An access to another register cancels the armed state, unless a status read occurs in the same cycle. A status read always arms the sequence.
- R10: Each enable input gates a set of flags:
  - `en_tx` gates bit 7.
  - `en_done` gates bit 6.
  - `en_rx` gates bits 5 and 3.
  - `en_idle` gates bit 4.
  - `en_parity` gates bit 0.

  A flag that is set and enabled counts as pending. Noise and framing error never count as pending.
- R11: `irq` is high when any flag is pending and `irq_mask` is low.
- R12: `pwr_mode` encoding: 2'b00 = run, 2'b01 = wait, 2'b10 or 2'b11 = halt. `wake` is high only in wait mode with a pending flag, whatever the value of `irq_mask`.
- R13: In halt mode, all flags and the armed state hold their values, and events and bus strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_txbuf_moved | input | 1 | Pending transmit byte moved into the shifter |
| ev_frame_done | input | 1 | Last frame ended, no byte waiting |
| ev_rx_byte | input | 1 | Received byte available |
| ev_overrun | input | 1 | Byte lost, receive buffer still full |
| ev_idle | input | 1 | Idle line seen |
| ev_noise | input | 1 | Noise seen in a frame |
| ev_frame_err | input | 1 | Stop bit missing |
| ev_parity_err | input | 1 | Parity mismatch |
| bus_stat_rd | input | 1 | Status register read strobe |
| bus_data_rd | input | 1 | Data register read strobe |
| bus_data_wr | input | 1 | Data register write strobe |
| bus_other_acc | input | 1 | Access to any other register of the port |
| en_tx | input | 1 | Enable for buffer-empty interrupt |
| en_done | input | 1 | Enable for transmission-complete interrupt |
| en_rx | input | 1 | Enable for receive-ready and overrun interrupt |
| en_idle | input | 1 | Enable for idle-line interrupt |
| en_parity | input | 1 | Enable for parity interrupt |
| irq_mask | input | 1 | Global interrupt mask, high blocks `irq` |
| pwr_mode | input | 2 | Power mode: 00 run, 01 wait, 1x halt |
| status | output | 8 | Status word |
| irq | output | 1 | Shared interrupt request |
| wake | output | 1 | Wake request in wait mode |
| load_ok | output | 1 | Transmitter may load its shifter |

## Verification
The hardest state to reach is the armed clear sequence interacting with other traffic. Examples are a status read followed by a write that consumes the armed state, so that a later read must not clear the receive flags. Another is a status read together with another access in one cycle. A third is a clear that lands on the same edge as a new event. The vector table reaches these by walking short bus sequences from a known flag state: arm, cancel, consume, then retry. It also raises every flag first, so that a wrong clear shows as a changed status word. Halt-mode vectors issue a status read and events, then return to run mode and write the data register, which exposes any arming or setting that leaked through the freeze.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int STAT_W = 8;
  localparam logic [STAT_W-1:0] STAT_RST = 8'hC0;

  // flag positions in the status word
  localparam int B_TXE   = 7;
  localparam int B_TC    = 6;
  localparam int B_RXR   = 5;
  localparam int B_IDLE  = 4;
  localparam int B_OVR   = 3;
  localparam int B_NOISE = 2;
  localparam int B_FERR  = 1;
  localparam int B_PERR  = 0;

  // flags at or above this index belong to the transmit clear group
  localparam int TX_GROUP_LO = B_TC;

  localparam int N_EN = 5;
  localparam int E_TX = 4, E_DONE = 3, E_RX = 2, E_IDLE = 1, E_PAR = 0;

  typedef enum logic [1:0] {
    PM_RUN   = 2'b00,
    PM_WAIT  = 2'b01,
    PM_HALT  = 2'b10,
    PM_HALTX = 2'b11
  } pwr_mode_e;
endpackage

// File: rtl/usf_flag_cell.sv
module usf_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      q <= RST_VAL;
    else if (!hold) begin
      if (set_i)      q <= 1'b1;   // a new event beats a clear
      else if (clr_i) q <= 1'b0;
    end
  end
endmodule

// File: rtl/usf_clear_seq.sv
module usf_clear_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic stat_rd,
  input  logic data_rd,
  input  logic data_wr,
  input  logic other_acc,
  output logic armed,
  output logic clr_tx,
  output logic clr_rx
);
  logic armed_nxt;

  always_comb begin
    armed_nxt = armed;
    if (stat_rd)
      armed_nxt = 1'b1;
    else if (data_rd || data_wr || other_acc)
      armed_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      armed <= 1'b0;
    else if (!hold)
      armed <= armed_nxt;
  end

  assign clr_tx = armed && data_wr && !hold;
  assign clr_rx = armed && data_rd && !hold;
endmodule

// File: rtl/usf_irq_comb.sv
module usf_irq_comb
  import uart_stat_pkg::*;
(
  input  logic [STAT_W-1:0] flags,
  input  logic [N_EN-1:0]   en,
  input  logic              mask,
  input  logic [1:0]        mode,
  output logic              irq,
  output logic              wake
);
  logic [N_EN-1:0] src;
  logic            pend;

  always_comb begin
    src[E_TX]   = flags[B_TXE];
    src[E_DONE] = flags[B_TC];
    src[E_RX]   = flags[B_RXR] | flags[B_OVR];
    src[E_IDLE] = flags[B_IDLE];
    src[E_PAR]  = flags[B_PERR];
  end

  assign pend = |(src & en);
  assign irq  = pend && !mask;
  assign wake = pend && (pwr_mode_e'(mode) == PM_WAIT);
endmodule

// File: rtl/uart_stat_irq.sv
module uart_stat_irq
  import uart_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_txbuf_moved,
  input  logic              ev_frame_done,
  input  logic              ev_rx_byte,
  input  logic              ev_overrun,
  input  logic              ev_idle,
  input  logic              ev_noise,
  input  logic              ev_frame_err,
  input  logic              ev_parity_err,
  input  logic              bus_stat_rd,
  input  logic              bus_data_rd,
  input  logic              bus_data_wr,
  input  logic              bus_other_acc,
  input  logic              en_tx,
  input  logic              en_done,
  input  logic              en_rx,
  input  logic              en_idle,
  input  logic              en_parity,
  input  logic              irq_mask,
  input  logic [1:0]        pwr_mode,
  output logic [STAT_W-1:0] status,
  output logic              irq,
  output logic              wake,
  output logic              load_ok
);
  logic [STAT_W-1:0] ev_vec;
  logic [N_EN-1:0]   en_vec;
  logic              halted;
  logic              armed;
  logic              clr_tx;
  logic              clr_rx;

  assign halted = pwr_mode[1];

  always_comb begin
    ev_vec          = '0;
    ev_vec[B_TXE]   = ev_txbuf_moved;
    ev_vec[B_TC]    = ev_frame_done;
    ev_vec[B_RXR]   = ev_rx_byte;
    ev_vec[B_IDLE]  = ev_idle;
    ev_vec[B_OVR]   = ev_overrun;
    ev_vec[B_NOISE] = ev_noise;
    ev_vec[B_FERR]  = ev_frame_err;
    ev_vec[B_PERR]  = ev_parity_err;
  end

  assign en_vec = {en_tx, en_done, en_rx, en_idle, en_parity};

  usf_clear_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (halted),
    .stat_rd   (bus_stat_rd),
    .data_rd   (bus_data_rd),
    .data_wr   (bus_data_wr),
    .other_acc (bus_other_acc),
    .armed     (armed),
    .clr_tx    (clr_tx),
    .clr_rx    (clr_rx)
  );

  for (genvar i = 0; i < STAT_W; i++) begin : g_flag
    logic clr_sel;
    if (i >= TX_GROUP_LO) begin : g_txgrp
      assign clr_sel = clr_tx;
    end else begin : g_rxgrp
      assign clr_sel = clr_rx;
    end
    usf_flag_cell #(.RST_VAL(STAT_RST[i])) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (halted),
      .set_i (ev_vec[i] && !halted),
      .clr_i (clr_sel),
      .q     (status[i])
    );
  end

  usf_irq_comb u_irq (
    .flags (status),
    .en    (en_vec),
    .mask  (irq_mask),
    .mode  (pwr_mode),
    .irq   (irq),
    .wake  (wake)
  );

  assign load_ok = !status[B_TXE];
endmodule

// File: rtl/uart_stat_irq_chk.sv
module uart_stat_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_txbuf_moved,
  input logic       ev_rx_byte,
  input logic       bus_stat_rd,
  input logic       bus_data_wr,
  input logic       bus_other_acc,
  input logic       irq_mask,
  input logic [1:0] pwr_mode,
  input logic [7:0] status,
  input logic       irq,
  input logic       wake,
  input logic       armed
);
  logic seen;
  always_ff @(posedge clk) seen <= rst_n;

  a_r2_reset_word: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> status == 8'hC0);

  a_r3_txe_set: assert property (@(posedge clk) disable iff (!rst_n)
    ev_txbuf_moved && !pwr_mode[1] |=> status[7]);

  a_r4_no_unarmed_clear: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] && bus_data_wr && !armed && !pwr_mode[1] |=> status[7]);

  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_byte && !pwr_mode[1] |=> status[5]);

  a_r9_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    bus_other_acc && !bus_stat_rd && !pwr_mode[1] |=> !armed);

  a_r11_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !irq);

  a_r12_wake_mode: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_mode != 2'b01 |-> !wake);

  a_r13_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_mode[1] |=> $stable(status));
endmodule

bind uart_stat_irq uart_stat_irq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ev_txbuf_moved (ev_txbuf_moved),
  .ev_rx_byte     (ev_rx_byte),
  .bus_stat_rd    (bus_stat_rd),
  .bus_data_wr    (bus_data_wr),
  .bus_other_acc  (bus_other_acc),
  .irq_mask       (irq_mask),
  .pwr_mode       (pwr_mode),
  .status         (status),
  .irq            (irq),
  .wake           (wake),
  .armed          (armed)
);

// File: tb/uart_stat_irq_tb.sv
`timescale 1ns/1ps
module uart_stat_irq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] ev = '0;       // bit order matches status word (R1)
  logic [3:0] bus = '0;      // {stat_rd, data_rd, data_wr, other}
  logic [4:0] en = '0;       // {tx, done, rx, idle, parity}
  logic       mask = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] status;
  logic       irq, wake, load_ok;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_stat_irq u_dut (
    .clk(clk), .rst_n(rst_n),
    .ev_txbuf_moved(ev[7]), .ev_frame_done(ev[6]), .ev_rx_byte(ev[5]),
    .ev_idle(ev[4]), .ev_overrun(ev[3]), .ev_noise(ev[2]),
    .ev_frame_err(ev[1]), .ev_parity_err(ev[0]),
    .bus_stat_rd(bus[3]), .bus_data_rd(bus[2]), .bus_data_wr(bus[1]),
    .bus_other_acc(bus[0]),
    .en_tx(en[4]), .en_done(en[3]), .en_rx(en[2]), .en_idle(en[1]),
    .en_parity(en[0]), .irq_mask(mask), .pwr_mode(mode),
    .status(status), .irq(irq), .wake(wake), .load_ok(load_ok)
  );

  // {ev, bus, en, mask, mode, exp_status, exp_irq, exp_wake, exp_ld, req}
  localparam int NV = 27;
  localparam logic [34:0] VEC [NV] = '{
    {8'h00,4'b0000,5'b00000,1'b0,2'b00, 8'hC0,1'b0,1'b0,1'b0, 4'd2},  // R2
    {8'h00,4'b0000,5'b10000,1'b0,2'b00, 8'hC0,1'b1,1'b0,1'b0, 4'd10}, // R10
    {8'h00,4'b0000,5'b10000,1'b1,2'b00, 8'hC0,1'b0,1'b0,1'b0, 4'd11}, // R11
    {8'h00,4'b0000,5'b10000,1'b0,2'b01, 8'hC0,1'b1,1'b1,1'b0, 4'd12}, // R12
    {8'h00,4'b0000,5'b10000,1'b1,2'b01, 8'hC0,1'b0,1'b1,1'b0, 4'd12}, // R12
    {8'h00,4'b0010,5'b00000,1'b0,2'b00, 8'hC0,1'b0,1'b0,1'b0, 4'd4},  // R4 unarmed
    {8'h00,4'b1000,5'b00000,1'b0,2'b00, 8'hC0,1'b0,1'b0,1'b0, 4'd4},  // arm
    {8'h00,4'b0001,5'b00000,1'b0,2'b00, 8'hC0,1'b0,1'b0,1'b0, 4'd9},  // R9 cancel
    {8'h00,4'b0010,5'b00000,1'b0,2'b00, 8'hC0,1'b0,1'b0,1'b0, 4'd9},
    {8'h00,4'b1000,5'b00000,1'b0,2'b00, 8'hC0,1'b0,1'b0,1'b0, 4'd4},
    {8'h00,4'b0010,5'b00000,1'b0,2'b00, 8'h00,1'b0,1'b0,1'b1, 4'd5},  // R4 R5
    {8'h20,4'b0000,5'b00100,1'b0,2'b00, 8'h20,1'b1,1'b0,1'b1, 4'd7},  // R7
    {8'h0E,4'b0000,5'b00000,1'b0,2'b00, 8'h2E,1'b0,1'b0,1'b1, 4'd10}, // R10 noise/fe
    {8'h10,4'b0000,5'b00010,1'b0,2'b00, 8'h3E,1'b1,1'b0,1'b1, 4'd10},
    {8'h01,4'b0000,5'b00001,1'b0,2'b00, 8'h3F,1'b1,1'b0,1'b1, 4'd10},
    {8'h00,4'b1000,5'b00000,1'b0,2'b00, 8'h3F,1'b0,1'b0,1'b1, 4'd9},
    {8'h00,4'b0010,5'b00000,1'b0,2'b00, 8'h3F,1'b0,1'b0,1'b1, 4'd9},  // consumed
    {8'h00,4'b0100,5'b00000,1'b0,2'b00, 8'h3F,1'b0,1'b0,1'b1, 4'd9},
    {8'h00,4'b1000,5'b00000,1'b0,2'b00, 8'h3F,1'b0,1'b0,1'b1, 4'd7},
    {8'h04,4'b0100,5'b00000,1'b0,2'b00, 8'h04,1'b0,1'b0,1'b1, 4'd8},  // R8
    {8'h80,4'b0000,5'b10000,1'b0,2'b00, 8'h84,1'b1,1'b0,1'b0, 4'd3},  // R3
    {8'h40,4'b0000,5'b01000,1'b0,2'b00, 8'hC4,1'b1,1'b0,1'b0, 4'd6},  // R6
    {8'h20,4'b1000,5'b00100,1'b0,2'b10, 8'hC4,1'b0,1'b0,1'b0, 4'd13}, // R13
    {8'h00,4'b0000,5'b10000,1'b0,2'b11, 8'hC4,1'b1,1'b0,1'b0, 4'd13},
    {8'h00,4'b0010,5'b00000,1'b0,2'b00, 8'hC4,1'b0,1'b0,1'b0, 4'd13},
    {8'h00,4'b1000,5'b00000,1'b0,2'b00, 8'hC4,1'b0,1'b0,1'b0, 4'd4},
    {8'h80,4'b0010,5'b00000,1'b0,2'b00, 8'h84,1'b0,1'b0,1'b0, 4'd8}   // R8 tx
  };

  task automatic check(input string req, input logic [10:0] got, input logic [10:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got status=%h irq=%b wake=%b ld=%b, expected status=%h irq=%b wake=%b ld=%b",
               req, got[10:3], got[2], got[1], got[0], exp[10:3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic step(input logic [7:0] e, input logic [3:0] b);
    @(negedge clk);
    ev = e; bus = b;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2", {status, irq, wake, load_ok}, {8'hC0, 3'b000});
    rst_n = 1'b1;
    foreach (VEC[i]) begin
      @(negedge clk);
      ev = VEC[i][34:27]; bus = VEC[i][26:23]; en = VEC[i][22:18];
      mask = VEC[i][17]; mode = VEC[i][16:15];
      @(posedge clk); #1;
      check($sformatf("R%0d vec %0d", VEC[i][3:0], i),
            {status, irq, wake, load_ok}, VEC[i][14:4]);
    end
    // R9: status read and other access in one cycle still arms
    en = '0; mask = 1'b0; mode = 2'b00;
    step(8'h00, 4'b1001);
    step(8'h00, 4'b0010);
    check("R9 same-cycle arm", {status, irq, wake, load_ok}, {8'h04, 3'b001});
    // R4: a read consumes the arm, so the later write must not clear
    step(8'h80, 4'b0000);
    step(8'h00, 4'b1000);
    step(8'h00, 4'b0100);
    check("R7 read clears rx", {status, irq, wake, load_ok}, {8'h80, 3'b000});
    step(8'h00, 4'b0010);
    check("R4 write after consumed arm", {status, irq, wake, load_ok}, {8'h80, 3'b000});
    // R2: reset mid-run restores the reset word
    step(8'h00, 4'b0000);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    check("R2 mid-run reset", {status, irq, wake, load_ok}, {8'hC0, 3'b000});
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule